// File: doc/BRIEF.md
# Parallel Flash Bus Mode Controller

This block sits behind the host-facing pins of a parallel NOR-style flash device. It samples chip enable, output enable, write enable, the hardware reset pin, the width select pin and the address bus on a synchronous system clock. From these it decides which bus cycle is under way: read, command write, output-disabled or standby. It then drives the per-lane output enables and the data returned to the host. The array itself and command interpretation live elsewhere. The block takes the array's read word on `arr_rdata` and the program/erase engine's running flag on `op_busy`.

In narrow (byte) mode only the low eight lanes ever drive. The input half of the top data pin is used as the least-significant byte address bit, and it chooses which half of the array word reaches lanes 7..0. An address-stability timer puts the block into sleep once the effective address has been held for a set number of clock cycles. In sleep the last read data stays latched on the outputs, and any address change wakes the block again. The reset pin clears all registered state at once and masks every bus cycle while it is held low.

All outputs are registered. A pin pattern present at a rising clock edge shows up on the outputs just after that edge.

Top module: `flash_busctl`

## Requirements
- R1: With `wide`=1 and a read pattern (`ce_n`=0, `oe_n`=0, `we_n`=1), `dq_oe` becomes 16'hFFFF after the edge, and `dq_out` takes the full `arr_rdata` word.
- R2: With `wide`=0 and a read pattern, `dq_oe` becomes 16'h00FF, so lanes 8..15 stay off. `dq_out[7:0]` takes `arr_rdata[15:8]` when `dq15_in`=1 and `arr_rdata[7:0]` when `dq15_in`=0, and `dq_out[15:8]` is 0.
- R3: `byte_addr` is `{addr, dq15_in}` when `wide`=0 and `{addr, 1'b0}` when `wide`=1.
- R4: `rd_cyc` is 1 exactly after an edge that saw the read pattern. `wr_cyc` is 1 exactly after an edge that saw `ce_n`=0, `we_n`=0, `oe_n`=1. The two are never 1 together.
- R5: After any edge with `oe_n`=1, `dq_oe` is 0. `out_dis` is 1 when that edge also had `ce_n`=0.
- R6: After any edge with `ce_n`=1 and the reset pin high, `standby` is 1 and `dq_oe` is 0.
- R7: While `rst_pin_n` is 0, `dq_oe`, `dq_out`, every mode flag, `busy` and `sleep` are 0 whatever the other pins do. After release the sleep count starts again from zero.
- R8: `sleep` rises after the SLEEP_CYC-th consecutive edge at which `byte_addr` would not change. Chip enable, output enable and write enable have no effect on this.
- R9: While `sleep` is 1, `dq_out` holds its value even if `arr_rdata` changes. An edge that changes the effective address clears `sleep` and lets a read load fresh data on that same edge.
- R10: `busy` follows `op_busy` one edge later regardless of `ce_n`, so deselecting the device does not hide a running operation. The reset pin forces it to 0.
- R11: When no read is in progress, `dq_out` keeps the last value loaded by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pins sampled on its rising edge |
| rst_pin_n | input | 1 | Hardware reset pin, active low, asynchronous clear |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide | input | 1 | Width select: 1 = 16-bit word, 0 = 8-bit byte |
| addr | input | AW | Host address bus |
| dq15_in | input | 1 | Input half of the top data pin (lowest address bit in byte mode) |
| arr_rdata | input | 16 | Word currently presented by the array at the address |
| op_busy | input | 1 | Program/erase engine is running |
| dq_out | output | 16 | Latched read data toward the data pins |
| dq_oe | output | 16 | Per-lane output enables for the data pins |
| byte_addr | output | AW+1 | Effective byte address, including the lowest bit |
| rd_cyc | output | 1 | Read cycle in progress |
| wr_cyc | output | 1 | Command write cycle in progress |
| out_dis | output | 1 | Selected with outputs disabled |
| standby | output | 1 | Deselected while out of reset |
| sleep | output | 1 | Automatic sleep active |
| busy | output | 1 | Program/erase still running |

## Verification
The assertions check the per-cycle rules on every clock. These are the lane masks for each width, the high-impedance lanes when output enable is high or the device is deselected, the read/write exclusion, the quiet outputs under reset, busy following the engine, and data holding steady through sleep. Other behaviour can only be shown by the bench's scenarios. This covers the exact edge on which sleep is entered, waking on a change of only the lowest byte-address bit, which half of the word is steered in byte mode, and data surviving the end of a read. The bench checks these against a reference model running random traffic and directed sequences.

// File: rtl/flash_busctl_pkg.sv
package flash_busctl_pkg;

    localparam int DQ_W   = 16;
    localparam int HALF_W = DQ_W / 2;

    typedef enum logic [2:0] {
        BUS_STANDBY = 3'd0,
        BUS_READ    = 3'd1,
        BUS_WRITE   = 3'd2,
        BUS_OUTOFF  = 3'd3,
        BUS_CLASH   = 3'd4
    } bus_mode_e;

endpackage

// File: rtl/flash_busctl_decode.sv
module flash_busctl_decode
    import flash_busctl_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    output bus_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = BUS_STANDBY;
        end else if (oe_n) begin
            mode = we_n ? BUS_OUTOFF : BUS_WRITE;
        end else begin
            // output enable low: a read only if write enable stays high
            mode = we_n ? BUS_READ : BUS_CLASH;
        end
    end

endmodule

// File: rtl/flash_busctl_steer.sv
module flash_busctl_steer
    import flash_busctl_pkg::*;
(
    input  logic            read_en,
    input  logic            wide,
    input  logic            a_lsb,
    input  logic [DQ_W-1:0] arr_word,
    output logic [DQ_W-1:0] lane_en,
    output logic [DQ_W-1:0] lane_data
);

    for (genvar i = 0; i < DQ_W; i++) begin : g_lane
        if (i < HALF_W) begin : g_low
            assign lane_en[i]   = read_en;
            assign lane_data[i] = (wide || !a_lsb) ? arr_word[i] : arr_word[i + HALF_W];
        end else begin : g_high
            assign lane_en[i]   = read_en & wide;
            assign lane_data[i] = wide & arr_word[i];
        end
    end

endmodule

// File: rtl/flash_busctl_sleep.sv
module flash_busctl_sleep #(
    parameter int SLEEP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic moved,
    output logic sleep_nxt,
    output logic sleep_q
);

    localparam int CW = $clog2(SLEEP_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          asleep;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        t_d     = t_q;
        cnt_inc = t_q.cnt + CW'(1);
        if (moved) begin
            t_d.cnt    = '0;
            t_d.asleep = 1'b0;
        end else if (!t_q.asleep) begin
            t_d.cnt    = cnt_inc;
            t_d.asleep = (cnt_inc == CW'(SLEEP_CYC));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sleep_nxt = t_d.asleep;
    assign sleep_q   = t_q.asleep;

endmodule

// File: rtl/flash_busctl.sv
module flash_busctl
    import flash_busctl_pkg::*;
#(
    parameter int AW        = 20,
    parameter int SLEEP_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_pin_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            wide,
    input  logic [AW-1:0]   addr,
    input  logic            dq15_in,
    input  logic [DQ_W-1:0] arr_rdata,
    input  logic            op_busy,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe,
    output logic [AW:0]     byte_addr,
    output logic            rd_cyc,
    output logic            wr_cyc,
    output logic            out_dis,
    output logic            standby,
    output logic            sleep,
    output logic            busy
);

    localparam int BAW = AW + 1;

    typedef struct packed {
        logic [DQ_W-1:0] oe;
        logic [DQ_W-1:0] data;
        logic [BAW-1:0]  baddr;
        logic            rd;
        logic            wr;
        logic            odis;
        logic            stby;
        logic            busy;
    } st_t;

    st_t       st_d, st_q;
    bus_mode_e mode;
    logic      is_read;
    logic      moved;
    logic      sleep_nxt;
    logic      sleep_q;
    logic [DQ_W-1:0] lane_en;
    logic [DQ_W-1:0] lane_data;

    flash_busctl_decode u_decode (
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .mode (mode)
    );

    assign is_read = (mode == BUS_READ);

    flash_busctl_steer u_steer (
        .read_en   (is_read),
        .wide      (wide),
        .a_lsb     (dq15_in),
        .arr_word  (arr_rdata),
        .lane_en   (lane_en),
        .lane_data (lane_data)
    );

    flash_busctl_sleep #(
        .SLEEP_CYC (SLEEP_CYC)
    ) u_sleep (
        .clk       (clk),
        .rst_n     (rst_pin_n),
        .moved     (moved),
        .sleep_nxt (sleep_nxt),
        .sleep_q   (sleep_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.baddr = {addr, (wide ? 1'b0 : dq15_in)};
        moved      = (st_d.baddr != st_q.baddr);
        st_d.rd    = is_read;
        st_d.wr    = (mode == BUS_WRITE);
        st_d.odis  = (mode == BUS_WRITE) || (mode == BUS_OUTOFF);
        st_d.stby  = (mode == BUS_STANDBY);
        st_d.oe    = lane_en;
        st_d.busy  = op_busy;
        // data latch: loads only on a read edge that does not stay asleep
        if (is_read && !sleep_nxt) begin
            st_d.data = lane_data;
        end
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out    = st_q.data;
    assign dq_oe     = st_q.oe;
    assign byte_addr = st_q.baddr;
    assign rd_cyc    = st_q.rd;
    assign wr_cyc    = st_q.wr;
    assign out_dis   = st_q.odis;
    assign standby   = st_q.stby;
    assign sleep     = sleep_q;
    assign busy      = st_q.busy;

endmodule

// File: rtl/flash_busctl_chk.sv
module flash_busctl_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_pin_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          wide,
    input logic [AW-1:0] addr,
    input logic          dq15_in,
    input logic          op_busy,
    input logic [15:0]   dq_out,
    input logic [15:0]   dq_oe,
    input logic          rd_cyc,
    input logic          wr_cyc,
    input logic          standby,
    input logic          sleep,
    input logic          busy
);

    logic rd_pat;
    assign rd_pat = !ce_n && !oe_n && we_n;

    // R1: full width lanes on a word read
    a_r1_word_lanes: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (rd_pat && wide) |=> (dq_oe == 16'hFFFF));

    // R2: only the low byte lanes on a byte read
    a_r2_byte_lanes: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (rd_pat && !wide) |=> (dq_oe == 16'h00FF));

    // R4: read flag follows the read pattern
    a_r4_read_flag: assert property (@(posedge clk) disable iff (!rst_pin_n)
        rd_pat |=> rd_cyc);

    // R4: read and write never reported together
    a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !(rd_cyc && wr_cyc));

    // R5: output enable high means every lane off
    a_r5_oe_hiz: assert property (@(posedge clk) disable iff (!rst_pin_n)
        oe_n |=> (dq_oe == 16'h0000));

    // R6: deselected means standby with lanes off
    a_r6_standby: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ce_n |=> (standby && dq_oe == 16'h0000));

    // R7: reset pin quiets every output
    a_r7_reset_quiet: assert property (@(posedge clk)
        !rst_pin_n |=> (dq_oe == 16'h0000 && dq_out == 16'h0000 && !rd_cyc
                        && !wr_cyc && !busy && !sleep));

    // R9: data frozen while asleep with the address held
    a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (sleep && $stable(addr) && $stable(wide) && $stable(dq15_in)) |=> $stable(dq_out));

    // R9: a new address wakes the block
    a_r9_sleep_exit: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !$stable(addr) |=> !sleep);

    // R10: busy tracks the engine regardless of chip enable
    a_r10_busy_follow: assert property (@(posedge clk) disable iff (!rst_pin_n)
        op_busy |=> busy);

endmodule

bind flash_busctl flash_busctl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .wide      (wide),
    .addr      (addr),
    .dq15_in   (dq15_in),
    .op_busy   (op_busy),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .standby   (standby),
    .sleep     (sleep),
    .busy      (busy)
);

// File: tb/flash_busctl_tb.sv
`timescale 1ns/1ps
module flash_busctl_tb;

    localparam int AW    = 20;
    localparam int SLEEP = 6;

    logic          clk = 1'b0;
    logic          rst_pin_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          dq15_in = 1'b0;
    logic [15:0]   arr_rdata = '0;
    logic          op_busy = 1'b0;
    logic [15:0]   dq_out, dq_oe;
    logic [AW:0]   byte_addr;
    logic          rd_cyc, wr_cyc, out_dis, standby, sleep, busy;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // reference model state
    logic [15:0] m_oe, m_out;
    logic [AW:0] m_baddr;
    logic        m_rd, m_wr, m_odis, m_stby, m_sleep, m_busy;
    int          m_cnt;

    always #2 clk = ~clk;

    flash_busctl #(.AW(AW), .SLEEP_CYC(SLEEP)) u_dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wide(wide), .addr(addr), .dq15_in(dq15_in), .arr_rdata(arr_rdata),
        .op_busy(op_busy), .dq_out(dq_out), .dq_oe(dq_oe), .byte_addr(byte_addr),
        .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .out_dis(out_dis), .standby(standby),
        .sleep(sleep), .busy(busy)
    );

    function automatic logic [15:0] exp_data(logic w, logic lsb, logic [15:0] a);
        if (w) return a;
        return {8'h00, (lsb ? a[15:8] : a[7:0])};
    endfunction

    function automatic logic [15:0] exp_mask(logic w);
        return w ? 16'hFFFF : 16'h00FF;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [AW:0] ba;
        logic rd;
        if (!rst_pin_n) begin
            m_oe = '0; m_out = '0; m_baddr = '0; m_rd = 0; m_wr = 0;
            m_odis = 0; m_stby = 0; m_sleep = 0; m_busy = 0; m_cnt = 0;
        end else begin
            ba = {addr, (wide ? 1'b0 : dq15_in)};
            if (ba != m_baddr) begin
                m_cnt = 0; m_sleep = 0;
            end else if (!m_sleep) begin
                m_cnt++;
                if (m_cnt == SLEEP) m_sleep = 1;
            end
            m_baddr = ba;
            rd      = !ce_n && !oe_n && we_n;
            m_rd    = rd;
            m_wr    = !ce_n && !we_n && oe_n;
            m_odis  = !ce_n && oe_n;
            m_stby  = ce_n;
            m_oe    = rd ? exp_mask(wide) : 16'h0000;
            m_busy  = op_busy;
            if (rd && !m_sleep) m_out = exp_data(wide, dq15_in, arr_rdata);
        end
    endtask

    task automatic check_all();
        chk("R1", "dq_oe", 32'(dq_oe), 32'(m_oe));
        chk("R2", "dq_out", 32'(dq_out), 32'(m_out));
        chk("R3", "byte_addr", 32'(byte_addr), 32'(m_baddr));
        chk("R4", "rd/wr", {30'd0, rd_cyc, wr_cyc}, {30'd0, m_rd, m_wr});
        chk("R5", "out_dis", 32'(out_dis), 32'(m_odis));
        chk("R6", "standby", 32'(standby), 32'(m_stby));
        chk("R8", "sleep", 32'(sleep), 32'(m_sleep));
        chk("R10", "busy", 32'(busy), 32'(m_busy));
    endtask

    // one clock: inputs already set at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic pins(logic c, logic o, logic w);
        ce_n = c; oe_n = o; we_n = w;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R7: actual hung, expected finished run");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd20240611));
        m_cnt = 0;
        // R7: outputs quiet while reset pin held, even with a read pattern
        pins(0, 0, 1); op_busy = 1; arr_rdata = 16'hBEEF;
        repeat (3) step();
        chk("R7", "dq_oe in reset", 32'(dq_oe), 32'h0);
        chk("R7", "busy in reset", 32'(busy), 32'h0);
        @(negedge clk); rst_pin_n = 1; op_busy = 0; pins(1, 1, 1);
        step();

        // R1: word read
        wide = 1; addr = 20'h00123; arr_rdata = 16'hA55A; pins(0, 0, 1);
        step();
        chk("R1", "word data", 32'(dq_out), 32'hA55A);
        chk("R1", "word lanes", 32'(dq_oe), 32'hFFFF);

        // R2/R3: byte reads, both halves
        wide = 0; dq15_in = 1; arr_rdata = 16'h3C7E; step();
        chk("R2", "byte high half", 32'(dq_out), 32'h003C);
        chk("R3", "byte addr lsb1", 32'(byte_addr), {11'd0, 20'h00123, 1'b1});
        dq15_in = 0; step();
        chk("R2", "byte low half", 32'(dq_out), 32'h007E);
        chk("R2", "byte lanes", 32'(dq_oe), 32'h00FF);

        // R4/R11: write cycle keeps latched data, lanes off
        pins(0, 1, 0); arr_rdata = 16'h1111; step();
        chk("R4", "write flag", 32'(wr_cyc), 32'h1);
        chk("R11", "data held after read", 32'(dq_out), 32'h007E);
        // R5: output disable
        pins(0, 1, 1); step();
        chk("R5", "oe high lanes", 32'(dq_oe), 32'h0);
        // R6/R10: deselected while busy
        pins(1, 0, 1); op_busy = 1; step(); step();
        chk("R6", "standby", 32'(standby), 32'h1);
        chk("R10", "busy while deselected", 32'(busy), 32'h1);
        op_busy = 0; step();

        // R8/R9: sleep timing, hold, wake
        wide = 1; pins(0, 0, 1); addr = 20'h00456; arr_rdata = 16'h0F0F; step();
        for (int k = 1; k < SLEEP; k++) begin
            pins(k[0], 1, 1); step();
        end
        chk("R8", "not yet asleep", 32'(sleep), 32'h0);
        pins(0, 0, 1); step();
        chk("R8", "asleep on edge", 32'(sleep), 32'h1);
        held = dq_out;
        arr_rdata = 16'hDEAD; step();
        chk("R9", "data frozen asleep", 32'(dq_out), 32'(held));
        // R9: changing only the lowest byte address bit wakes it
        wide = 0; dq15_in = 1; step();
        chk("R9", "wake on lsb", 32'(sleep), 32'h0);
        chk("R9", "fresh data on wake", 32'(dq_out), 32'h00DE);

        // R7/R10: reset mid-run clears busy
        op_busy = 1; step();
        rst_pin_n = 0; step();
        chk("R7", "busy cleared", 32'(busy), 32'h0);
        rst_pin_n = 1; op_busy = 0; step();

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            {ce_n, oe_n, we_n} = r[2:0];
            if (r[4:3] == 2'b00) ce_n = 0;
            if (r[7:5] == 3'b000) wide = r[8];
            if (r[11:9] == 3'b000) addr = AW'(r[14:12]);
            if (r[17:15] == 3'b000) dq15_in = r[18];
            op_busy = r[19];
            rst_pin_n = (r[26:20] != 7'd0);
            arr_rdata = 16'($urandom);
            step();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule